// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Selectable Byte Order

This block is a small synchronous data store built from 32-bit words and addressed by byte. Word index n sits at byte address 4n. A single access port carries an address, write data, an access size (full word or single byte), a request strobe and a write-enable. Byte loads come back sign-extended to 32 bits. The port performs a word store, a byte store, a word load or a byte load in each cycle.

A static byte-order input sets which lane of a word a byte address picks. This applies to byte stores and byte loads alike. In big-endian order, byte offset 0 is the most significant byte. In little-endian order, byte offset 0 is the least significant byte. Word accesses reach the same storage word in both orders, and the word value does not depend on the byte order. A word access whose address is not a multiple of four raises an error flag and has no effect. A build-time parameter sets the load path: load data is either combinational for the present request or registered one cycle later.

Top module: `endian_byte_mem`

## Requirements
- R1: While reset is held and after it is released, every word reads as 0x00000000, `err_o` is 0 and `rdata_o` is 0 when no load is requested.
- R2: A word store with address bits [1:0] = 00 writes `wdata_i` to word index address[AW-1:2]. A later aligned word load from that address returns the same 32-bit value in either byte order.
- R3: With `big_endian_i` = 1, byte offset k (address bits [1:0]) maps to data bits [31-8k:24-8k]. Offset 0 is bits 31:24.
- R4: With `big_endian_i` = 0, byte offset k maps to data bits [8k+7:8k]. Offset 0 is bits 7:0.
- R5: A byte store replaces only the lane picked by R3/R4 with `wdata_i[7:0]` and leaves the other three bytes of the word unchanged.
- R6: A byte load returns the selected byte in bits 7:0, with bit 7 of that byte copied into bits 31:8.
- R7: A word access (`size_word_i` = 1) with address bits [1:0] not 00 drives `err_o` high in the same cycle as the request. It writes nothing, and if it is a load it returns 0x00000000.
- R8: Byte accesses never raise `err_o`, and `err_o` is 0 when `req_i` is 0.
- R9: With REG_READ = 0, load data appears in the cycle of the request. With REG_READ = 1, it appears one cycle later. In a cycle with no load request, the load result is 0x00000000.
- R10: After the word 0x23456789 is stored at address 0, a byte load from address 1 returns 0x00000045 in big-endian order and 0x00000067 in little-endian order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all words |
| big_endian_i | input | 1 | Static byte order: 1 = offset 0 is the most significant byte, 0 = least significant |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| size_word_i | input | 1 | 1 = 32-bit word access, 0 = single byte |
| addr_i | input | AW | Byte address; AW = log2(DEPTH) + 2 |
| wdata_i | input | 32 | Store data; a byte store uses bits 7:0 |
| rdata_o | output | 32 | Load result |
| err_o | output | 1 | Misaligned word access in the present cycle |

## Verification
A store changes storage at the rising edge that closes its request cycle, so a load in the next cycle must already see the new value. The bench keeps its model one step behind in exactly that way. `err_o` and the combinational load result are due in the cycle of the request, and the bench samples them a moment after driving inputs on the falling edge. The registered variant runs beside the combinational one on the same inputs. Its output is compared against the expected load result of the previous cycle, so every check of that variant sits exactly one cycle behind its stimulus.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFF_W-1:0]  lane_t;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;
endpackage

// File: rtl/ebm_addr_split.sv
module ebm_addr_split
    import ebm_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = AW - OFF_W
) (
    input  logic             big_endian_i,
    input  logic [AW-1:0]    addr_i,
    output logic [IDX_W-1:0] idx_o,
    output lane_t            lane_o,
    output logic             misaligned_o
);
    localparam lane_t LAST_LANE = lane_t'(WORD_BYTES - 1);

    lane_t       offset;
    byte_order_e order;

    always_comb begin
        order        = byte_order_e'(big_endian_i);
        offset       = addr_i[OFF_W-1:0];
        idx_o        = addr_i[AW-1:OFF_W];
        misaligned_o = (offset != '0);
        if (order == ORDER_BIG) begin
            lane_o = LAST_LANE - offset;
        end else begin
            lane_o = offset;
        end
    end
endmodule

// File: rtl/ebm_store_merge.sv
module ebm_store_merge
    import ebm_pkg::*;
(
    input  word_t old_word_i,
    input  word_t wdata_i,
    input  lane_t lane_i,
    input  logic  size_word_i,
    output word_t new_word_o
);
    logic [WORD_BYTES-1:0] lane_hit;

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_lane
            always_comb begin
                lane_hit[g] = (lane_i == lane_t'(g));
                if (size_word_i) begin
                    new_word_o[g*BYTE_W +: BYTE_W] = wdata_i[g*BYTE_W +: BYTE_W];
                end else if (lane_hit[g]) begin
                    new_word_o[g*BYTE_W +: BYTE_W] = wdata_i[BYTE_W-1:0];
                end else begin
                    new_word_o[g*BYTE_W +: BYTE_W] = old_word_i[g*BYTE_W +: BYTE_W];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ebm_load_format.sv
module ebm_load_format
    import ebm_pkg::*;
(
    input  word_t word_i,
    input  lane_t lane_i,
    input  logic  size_word_i,
    output word_t load_o
);
    logic [BYTE_W-1:0] lane_bytes [WORD_BYTES];
    logic [BYTE_W-1:0] picked;

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_split
            assign lane_bytes[g] = word_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        picked = lane_bytes[lane_i];
        if (size_word_i) begin
            load_o = word_i;
        end else begin
            load_o = {{(WORD_W-BYTE_W){picked[BYTE_W-1]}}, picked};
        end
    end
endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
    import ebm_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter bit REG_READ = 1'b0,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int AW       = IDX_W + OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_endian_i,
    input  logic          req_i,
    input  logic          we_i,
    input  logic          size_word_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o,
    output logic          err_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        word_t                        rd;
    } state_t;

    state_t           state_d;
    state_t           state_q;

    logic [IDX_W-1:0] idx;
    lane_t            lane;
    logic             misaligned;
    logic             bad_word;
    logic             store_ok;
    logic             load_ok;
    word_t            cur_word;
    word_t            merged;
    word_t            formatted;
    word_t            load_val;

    ebm_addr_split #(
        .AW    (AW),
        .IDX_W (IDX_W)
    ) u_split (
        .big_endian_i (big_endian_i),
        .addr_i       (addr_i),
        .idx_o        (idx),
        .lane_o       (lane),
        .misaligned_o (misaligned)
    );

    assign cur_word = state_q.mem[idx];

    ebm_store_merge u_merge (
        .old_word_i  (cur_word),
        .wdata_i     (wdata_i),
        .lane_i      (lane),
        .size_word_i (size_word_i),
        .new_word_o  (merged)
    );

    ebm_load_format u_format (
        .word_i      (cur_word),
        .lane_i      (lane),
        .size_word_i (size_word_i),
        .load_o      (formatted)
    );

    always_comb begin
        bad_word = req_i && size_word_i && misaligned;
        store_ok = req_i && we_i && !bad_word;
        load_ok  = req_i && !we_i && !bad_word;
        load_val = load_ok ? formatted : '0;

        state_d    = state_q;
        state_d.rd = load_val;
        if (store_ok) begin
            state_d.mem[idx] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = REG_READ ? state_q.rd : load_val;
    assign err_o   = bad_word;
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker
    import ebm_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter bit REG_READ = 1'b0,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int AW       = IDX_W + OFF_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         big_endian_i,
    input logic                         req_i,
    input logic                         we_i,
    input logic                         size_word_i,
    input logic [AW-1:0]                addr_i,
    input logic [31:0]                  wdata_i,
    input logic [31:0]                  rdata_o,
    input logic                         err_o,
    input logic [DEPTH-1:0][WORD_W-1:0] mem_q
);
    logic [IDX_W-1:0] c_idx;
    logic [1:0]       c_off;
    logic [1:0]       c_lane;
    word_t            c_keep;
    logic             c_word_store;
    logic             c_byte_store;
    logic             c_bad_store;
    logic             c_byte_load;
    logic             c_no_load;

    always_comb begin
        c_idx        = addr_i[AW-1:2];
        c_off        = addr_i[1:0];
        c_lane       = big_endian_i ? (2'd3 - c_off) : c_off;
        c_keep       = ~(word_t'(8'hFF) << (8 * c_lane));
        c_word_store = req_i && we_i && size_word_i && (c_off == 2'd0);
        c_bad_store  = req_i && we_i && size_word_i && (c_off != 2'd0);
        c_byte_store = req_i && we_i && !size_word_i;
        c_byte_load  = req_i && !we_i && !size_word_i;
        c_no_load    = !(req_i && !we_i);
    end

    // R2
    word_store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_word_store |=> (mem_q[$past(c_idx)] == $past(wdata_i)));

    // R5
    byte_store_confined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_byte_store |=> (((mem_q[$past(c_idx)] ^ $past(mem_q[c_idx])) & $past(c_keep)) == '0));

    // R7
    misaligned_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad_store |=> $stable(mem_q));

    // R8
    byte_access_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i || !size_word_i) |-> !err_o);

    generate
        if (REG_READ) begin : g_reg_chk
            // R6
            sign_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                c_byte_load |=> (rdata_o[31:8] == {24{rdata_o[7]}}));
            // R9
            idle_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                c_no_load |=> (rdata_o == 32'h0));
        end else begin : g_comb_chk
            // R6
            sign_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                c_byte_load |-> (rdata_o[31:8] == {24{rdata_o[7]}}));
            // R9
            idle_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                c_no_load |-> (rdata_o == 32'h0));
        end
    endgenerate
endmodule

bind endian_byte_mem ebm_checker #(
    .DEPTH    (DEPTH),
    .REG_READ (REG_READ),
    .IDX_W    (IDX_W),
    .AW       (AW)
) u_ebm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .big_endian_i (big_endian_i),
    .req_i        (req_i),
    .we_i         (we_i),
    .size_word_i  (size_word_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .err_o        (err_o),
    .mem_q        (state_q.mem)
);

// File: tb/test_endian_byte_mem.sv
`timescale 1ns/1ps
module test_endian_byte_mem;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          big_endian = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic          size_word = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata_c;
    logic [31:0]   rdata_r;
    logic          err_c;
    logic          err_r;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] model_mem [DEPTH];
    logic [31:0] reg_exp = '0;
    logic        be_mode = 1'b0;

    always #10 clk = ~clk;

    endian_byte_mem #(.DEPTH(DEPTH), .REG_READ(1'b0)) i_endian_byte_mem (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian), .req_i(req),
        .we_i(we), .size_word_i(size_word), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_c), .err_o(err_c));

    endian_byte_mem #(.DEPTH(DEPTH), .REG_READ(1'b1)) i_endian_byte_mem_reg (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian), .req_i(req),
        .we_i(we), .size_word_i(size_word), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_r), .err_o(err_r));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_load(input logic r, input logic w, input logic sw,
                                               input logic [AW-1:0] a, input logic b);
        logic [31:0] word;
        int          sel;
        logic [7:0]  by;
        if (!r || w) return 32'h0;
        word = model_mem[a[AW-1:2]];
        if (sw) return (a[1:0] != 2'd0) ? 32'h0 : word;
        sel = b ? (3 - int'(a[1:0])) : int'(a[1:0]);
        by  = word[8*sel +: 8];
        return {{24{by[7]}}, by};
    endfunction

    task automatic step(input logic r, input logic w, input logic sw,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        logic        exp_err;
        int          sel;
        @(negedge clk);
        big_endian = be_mode;
        req = r; we = w; size_word = sw; addr = a; wdata = d;
        #1;
        exp     = model_load(r, w, sw, a, be_mode);
        exp_err = r && sw && (a[1:0] != 2'd0);
        check({tag, " data"}, rdata_c, exp);
        check({tag, " err"}, {31'h0, err_c}, {31'h0, exp_err});
        check({tag, " err(reg)"}, {31'h0, err_r}, {31'h0, exp_err});
        check({tag, " R9 delayed data"}, rdata_r, reg_exp);
        reg_exp = exp;
        if (r && w && !exp_err) begin
            if (sw) begin
                model_mem[a[AW-1:2]] = d;
            end else begin
                sel = be_mode ? (3 - int'(a[1:0])) : int'(a[1:0]);
                model_mem[a[AW-1:2]][8*sel +: 8] = d[7:0];
            end
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset data", rdata_c, 32'h0);
        check("R1 reset err", {31'h0, err_c}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every word clear after reset
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, AW'(4 * i), 32'h0, "R1 cleared word");

        // R10 / R4 little-endian lanes
        be_mode = 1'b0;
        step(1, 1, 1, AW'(0), 32'h23456789, "R2 store");
        step(1, 0, 0, AW'(1), 32'h0, "R10 R4 le byte1");
        step(1, 0, 0, AW'(0), 32'h0, "R4 R6 le byte0");
        step(1, 0, 0, AW'(2), 32'h0, "R4 le byte2");
        step(1, 0, 0, AW'(3), 32'h0, "R4 le byte3");
        step(1, 0, 1, AW'(0), 32'h0, "R2 le word");

        // R10 / R3 big-endian lanes
        be_mode = 1'b1;
        step(0, 0, 0, AW'(0), 32'h0, "R9 idle");
        step(1, 0, 0, AW'(1), 32'h0, "R10 R3 be byte1");
        step(1, 0, 0, AW'(0), 32'h0, "R3 be byte0");
        step(1, 0, 0, AW'(3), 32'h0, "R3 R6 be byte3");
        step(1, 0, 1, AW'(0), 32'h0, "R2 be word");

        // R5 byte stores in each order
        step(1, 1, 1, AW'(12), 32'h11223344, "R2 store w3");
        step(1, 1, 0, AW'(12), 32'h000000AB, "R5 R3 be byte store");
        step(1, 0, 1, AW'(12), 32'h0, "R5 be merge");
        be_mode = 1'b0;
        step(0, 0, 0, AW'(0), 32'h0, "R9 idle");
        step(1, 1, 0, AW'(13), 32'hFFFFFF80, "R5 R4 le byte store");
        step(1, 0, 1, AW'(12), 32'h0, "R5 le merge");
        step(1, 0, 0, AW'(13), 32'h0, "R6 negative byte");

        // R7 misaligned word accesses, R8 byte accesses never flag
        step(1, 1, 1, AW'(6), 32'hDEADBEEF, "R7 misaligned store");
        step(1, 0, 1, AW'(4), 32'h0, "R7 word untouched");
        step(1, 0, 1, AW'(15), 32'h0, "R7 misaligned load");
        step(1, 1, 0, AW'(7), 32'h0000005A, "R8 byte store");
        step(1, 0, 0, AW'(7), 32'h0, "R8 byte load");
        step(0, 1, 1, AW'(5), 32'h12345678, "R8 no request");
        step(1, 0, 1, AW'(4), 32'h0, "R8 word after idle");

        // mixed pattern across both orders
        for (int i = 0; i < 48; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            if (i % 12 == 0) be_mode = ~be_mode;
            a = AW'((i * 7 + 3) % (4 * DEPTH));
            d = 32'h9E3779B9 * (i + 1);
            case (i % 4)
                0: step(1, 1, 1, a & ~AW'(3), d, "R2 mix word store");
                1: step(1, 1, 0, a, d, "R5 mix byte store");
                2: step(1, 0, 1, a & ~AW'(3), 32'h0, "R2 mix word load");
                default: step(1, 0, 0, a, 32'h0, "R6 mix byte load");
            endcase
        end
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, AW'(4 * i), 32'h0, "R5 final sweep");
        step(0, 0, 0, AW'(0), 32'h0, "R9 drain");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule